// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This block is a bus-mastering front end for a store of configuration items. The host puts a 16-byte descriptor somewhere in memory and writes that descriptor's 64-bit address into a small register window. The engine then fetches the descriptor one byte at a time over a simple memory master port. It decodes the control word and, if asked, selects a new item key. It then copies item bytes into host memory, copies host bytes into the item, or steps over item bytes. When it finishes, it stores a completion word back over the descriptor's control field.

The register window doubles as a presence probe: reads return a fixed 8-byte signature, sliced by the access offset and size. The item store sits behind a narrow port. The engine drives the current key and byte offset on it, and the store answers with validity, length, writability and the byte at that offset. One key is answered by the engine itself: a version item whose value tells firmware that DMA is available. The engine keeps a key/offset cursor that survives between transfers, so a transfer without a select continues where the previous one stopped.

Top module: `cfg_dma_engine`

## Requirements
- R1: A register read of `reg_size` bytes (1, 2, 4 or 8) at `reg_off` returns bytes `reg_off` to `reg_off+reg_size-1` of the 64-bit signature, counted from the most significant byte, right-aligned in `reg_rdata`. An unsupported size, or a span past byte 7, reads as zero.
- R2: Writes are accepted only while idle. A 4-byte write at offset 0 holds `reg_wdata[31:0]` as the high address half. A 4-byte write at offset 4 starts a transfer at {high half, `reg_wdata[31:0]`}. An 8-byte write at offset 0 starts a transfer at `reg_wdata`. Any other write does nothing. Each start clears the held high half.
- R3: The descriptor is read from bytes +0 to +15 of its address, all fields big-endian: a 32-bit control word at +0, a 32-bit length at +4, and a 64-bit target address at +8.
- R4: Control bit 3 selects an item before the move. The key comes from control bits 31:16, and the item offset rewinds to 0. Without bit 3, the key and offset are kept from the previous transfer.
- R5: The operation is chosen by priority: read (bit 1), then write (bit 4), then skip (bit 2). A control word with none of these bits moves nothing.
- R6: A read stores min(length, bytes left in item) item bytes to consecutive target addresses and advances the offset by that count. It then stores zeros for the rest of the length. An invalid key yields only zeros.
- R7: A skip advances the item offset by up to the length, stopping at the item end, and makes no memory access.
- R8: A write takes bytes from target memory into the item and advances the offset. It sets the error status, and stops before touching that byte, when the item is not writable or is exhausted.
- R9: On completion, four bytes are written at descriptor +0..+3 as a big-endian word: 0x00000000 on success, 0x00000001 on any error.
- R10: A memory error during the descriptor fetch stops the engine at once: no select and no move happen, and the error status is written back. A memory error during the move ends the loop with the error status, and later bytes are not touched.
- R11: Key 0x0001 is a read-only 4-byte item served by the engine, with bytes 0x03, 0x00, 0x00, 0x00. Bit 0x02 in its value advertises DMA alongside the base bit 0x01.
- R12: `busy` is high from the cycle after a start until the last write-back byte is acknowledged. `mem_req` stays asserted, with a stable address, until `mem_ack`, and is never asserted while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | 3 | Byte offset of register access |
| reg_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| reg_wdata | input | 64 | Write data, right-aligned |
| reg_rdata | output | 64 | Signature read data, right-aligned |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with ack |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Request failed, valid with ack |
| st_key | output | 16 | Current item key |
| st_off | output | 32 | Current byte offset in item |
| st_valid | input | 1 | Key names an existing item |
| st_len | input | 32 | Item length in bytes |
| st_wok | input | 1 | Item accepts writes |
| st_rdata | input | 8 | Item byte at `st_off` |
| st_we | output | 1 | Item byte write strobe |
| st_wdata | output | 8 | Item byte to store at `st_off` |

## Verification
The hardest situations to reach are the error exits. One is a memory fault that lands in the middle of a descriptor fetch, before the select is applied. The other is a fault partway through a move, after some bytes have already landed. The bench memory model faults one chosen address. Aiming that address at the descriptor's length field, or at the third target byte, forces each exit at a known point. The bench then checks that the status word reads 1 and that nothing beyond the fault was written. Stale high-address reuse is exposed by aliasing the high-half window onto a separate region of the model, so a held high half that was not cleared sends the fetch to the wrong bytes.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;

  localparam int DESC_BYTES = 16;
  localparam int WB_BYTES   = 4;

  // control word bit positions (decoded by the host side as well)
  localparam int CB_ERR   = 0;
  localparam int CB_READ  = 1;
  localparam int CB_SKIP  = 2;
  localparam int CB_SEL   = 3;
  localparam int CB_WRITE = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_STEP,
    ST_MWAIT,
    ST_WB
  } dma_state_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_READ,
    OP_WRITE,
    OP_SKIP
  } dma_op_e;

endpackage

// File: rtl/cfg_dma_regwin.sv
module cfg_dma_regwin #(
  parameter int          AW  = 64,
  parameter logic [63:0] SIG = 64'h5346_4744_4D41_4321
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [2:0]    off_i,
  input  logic [3:0]    size_i,
  input  logic [63:0]   wdata_i,
  input  logic          busy_i,
  output logic [63:0]   rdata_o,
  output logic          start_o,
  output logic [AW-1:0] start_addr_o
);

  localparam int HW = AW / 2;

  logic [HW-1:0] hi_q, hi_d;
  logic          size_ok;
  logic [4:0]    span;
  logic [63:0]   shifted;

  // signature slice: drop leading bytes, then keep the top size bytes
  always_comb begin
    size_ok = (size_i == 4'd1) || (size_i == 4'd2) ||
              (size_i == 4'd4) || (size_i == 4'd8);
    span    = {2'b00, off_i} + {1'b0, size_i};
    shifted = SIG << {off_i, 3'b000};
    if (size_ok && span <= 5'd8)
      rdata_o = shifted >> {4'd8 - size_i, 3'b000};
    else
      rdata_o = '0;
  end

  always_comb begin
    hi_d         = hi_q;
    start_o      = 1'b0;
    start_addr_o = '0;
    if (wr_i && !busy_i) begin
      if (size_i == 4'd4 && off_i == 3'd0) begin
        hi_d = wdata_i[HW-1:0];
      end else if (size_i == 4'd4 && off_i == 3'd4) begin
        start_o      = 1'b1;
        start_addr_o = {hi_q, wdata_i[HW-1:0]};
      end else if (size_i == 4'd8 && off_i == 3'd0) begin
        start_o      = 1'b1;
        start_addr_o = wdata_i[AW-1:0];
      end
    end
    if (start_o) hi_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_d;
  end

  p_addr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> (hi_q == '0));

endmodule

// File: rtl/cfg_dma_cursor.sv
module cfg_dma_cursor #(
  parameter int         KW      = 16,
  parameter int         OW      = 32,
  parameter logic [15:0] VER_KEY = 16'h0001,
  parameter logic [7:0] VER_VAL = 8'h03,
  parameter int         VER_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_i,
  input  logic [KW-1:0] sel_key_i,
  input  logic          adv_i,
  output logic [KW-1:0] st_key_o,
  output logic [OW-1:0] st_off_o,
  input  logic          st_valid_i,
  input  logic [OW-1:0] st_len_i,
  input  logic          st_wok_i,
  input  logic [7:0]    st_rdata_i,
  output logic          avail_o,
  output logic          wok_o,
  output logic [7:0]    byte_o
);

  logic [KW-1:0] key_q, key_d;
  logic [OW-1:0] off_q, off_d;
  logic          is_ver;

  always_comb begin
    key_d = key_q;
    off_d = off_q;
    if (sel_i) begin
      key_d = sel_key_i;
      off_d = '0;
    end else if (adv_i) begin
      off_d = off_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      off_q <= '0;
    end else begin
      key_q <= key_d;
      off_q <= off_d;
    end
  end

  // engine-served version item overlays the store for one key
  always_comb begin
    is_ver = (key_q == VER_KEY[KW-1:0]);
    if (is_ver) begin
      avail_o = (off_q < OW'(VER_LEN));
      wok_o   = 1'b0;
      byte_o  = (off_q == '0) ? VER_VAL : 8'h00;
    end else begin
      avail_o = st_valid_i && (off_q < st_len_i);
      wok_o   = st_wok_i;
      byte_o  = st_rdata_i;
    end
  end

  assign st_key_o = key_q;
  assign st_off_o = off_q;

  p_sel_rewind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i |=> (st_off_o == '0));

endmodule

// File: rtl/cfg_dma_ctrl.sv
module cfg_dma_ctrl
  import cfg_dma_pkg::*;
#(
  parameter int AW = 64,
  parameter int LW = 32,
  parameter int KW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  input  logic          mem_ack_i,
  input  logic          mem_err_i,
  output logic          sel_o,
  output logic [KW-1:0] sel_key_o,
  output logic          adv_o,
  input  logic          avail_i,
  input  logic          wok_i,
  input  logic [7:0]    item_byte_i,
  output logic          it_we_o,
  output logic [7:0]    it_wdata_o
);

  localparam int DW = DESC_BYTES * 8;
  localparam int IW = $clog2(DESC_BYTES);

  dma_state_e    state_q, state_d;
  dma_op_e       op_q, op_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] desc_q, desc_d;
  logic [AW-1:0] dptr_q, dptr_d;
  logic [LW-1:0] len_q, len_d;
  logic [AW-1:0] tgt_q, tgt_d;
  logic          err_q, err_d;
  logic          mreq_q, mreq_d;
  logic          mwe_q, mwe_d;
  logic [AW-1:0] maddr_q, maddr_d;
  logic [7:0]    mwd_q, mwd_d;
  logic [31:0]   ctl;
  logic          unused_ctl;

  assign ctl        = desc_q[DW-1 -: 32];
  assign unused_ctl = ^{ctl[15:5], ctl[CB_ERR]};

  always_comb begin
    state_d   = state_q;
    op_d      = op_q;
    idx_d     = idx_q;
    desc_d    = desc_q;
    dptr_d    = dptr_q;
    len_d     = len_q;
    tgt_d     = tgt_q;
    err_d     = err_q;
    mreq_d    = mreq_q;
    mwe_d     = mwe_q;
    maddr_d   = maddr_q;
    mwd_d     = mwd_q;
    sel_o     = 1'b0;
    sel_key_o = ctl[31:16];
    adv_o     = 1'b0;
    it_we_o   = 1'b0;
    it_wdata_o = mem_rdata_i;

    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          dptr_d  = start_addr_i;
          idx_d   = '0;
          err_d   = 1'b0;
          mreq_d  = 1'b1;
          mwe_d   = 1'b0;
          maddr_d = start_addr_i;
          state_d = ST_FETCH;
        end
      end

      ST_FETCH: begin
        if (mem_ack_i) begin
          if (mem_err_i) begin
            err_d   = 1'b1;
            idx_d   = '0;
            mreq_d  = 1'b1;
            mwe_d   = 1'b1;
            maddr_d = dptr_q;
            mwd_d   = 8'h00;
            state_d = ST_WB;
          end else begin
            desc_d = {desc_q[DW-9:0], mem_rdata_i};
            if (idx_q == IW'(DESC_BYTES - 1)) begin
              mreq_d  = 1'b0;
              state_d = ST_DECODE;
            end else begin
              idx_d   = idx_q + 1'b1;
              maddr_d = dptr_q + AW'(idx_q) + 1'b1;
            end
          end
        end
      end

      ST_DECODE: begin
        sel_o = ctl[CB_SEL];
        if (ctl[CB_READ])       op_d = OP_READ;
        else if (ctl[CB_WRITE]) op_d = OP_WRITE;
        else if (ctl[CB_SKIP])  op_d = OP_SKIP;
        else                    op_d = OP_NONE;
        len_d   = (ctl[CB_READ] || ctl[CB_WRITE] || ctl[CB_SKIP]) ?
                  desc_q[DW-33 -: LW] : '0;
        tgt_d   = desc_q[AW-1:0];
        state_d = ST_STEP;
      end

      ST_STEP: begin
        if (len_q == '0 || err_q) begin
          idx_d   = '0;
          mreq_d  = 1'b1;
          mwe_d   = 1'b1;
          maddr_d = dptr_q;
          mwd_d   = 8'h00;
          state_d = ST_WB;
        end else begin
          case (op_q)
            OP_READ: begin
              mreq_d  = 1'b1;
              mwe_d   = 1'b1;
              maddr_d = tgt_q;
              mwd_d   = avail_i ? item_byte_i : 8'h00;
              state_d = ST_MWAIT;
            end
            OP_WRITE: begin
              if (avail_i && wok_i) begin
                mreq_d  = 1'b1;
                mwe_d   = 1'b0;
                maddr_d = tgt_q;
                state_d = ST_MWAIT;
              end else begin
                err_d = 1'b1;
              end
            end
            OP_SKIP: begin
              adv_o = avail_i;
              len_d = len_q - 1'b1;
            end
            default: len_d = '0;
          endcase
        end
      end

      ST_MWAIT: begin
        if (mem_ack_i) begin
          mreq_d  = 1'b0;
          state_d = ST_STEP;
          if (mem_err_i) begin
            err_d = 1'b1;
          end else begin
            len_d = len_q - 1'b1;
            tgt_d = tgt_q + 1'b1;
            if (op_q == OP_WRITE) begin
              adv_o   = 1'b1;
              it_we_o = 1'b1;
            end else begin
              adv_o = avail_i;
            end
          end
        end
      end

      ST_WB: begin
        if (mem_ack_i) begin
          if (mem_err_i || idx_q == IW'(WB_BYTES - 1)) begin
            mreq_d  = 1'b0;
            state_d = ST_IDLE;
          end else begin
            idx_d   = idx_q + 1'b1;
            maddr_d = dptr_q + AW'(idx_q) + 1'b1;
            mwd_d   = (idx_q == IW'(WB_BYTES - 2)) ? {7'd0, err_q} : 8'h00;
          end
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      idx_q   <= '0;
      desc_q  <= '0;
      dptr_q  <= '0;
      len_q   <= '0;
      tgt_q   <= '0;
      err_q   <= 1'b0;
      mreq_q  <= 1'b0;
      mwe_q   <= 1'b0;
      maddr_q <= '0;
      mwd_q   <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      idx_q   <= idx_d;
      desc_q  <= desc_d;
      dptr_q  <= dptr_d;
      len_q   <= len_d;
      tgt_q   <= tgt_d;
      err_q   <= err_d;
      mreq_q  <= mreq_d;
      mwe_q   <= mwe_d;
      maddr_q <= maddr_d;
      mwd_q   <= mwd_d;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_req_o   = mreq_q;
  assign mem_we_o    = mwe_q;
  assign mem_addr_o  = maddr_q;
  assign mem_wdata_o = mwd_q;

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o);

  p_wb_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(mem_ack_i && mem_we_o));

  p_wr_allowed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    it_we_o |-> wok_i);

endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine #(
  parameter int          AW      = 64,
  parameter int          LW      = 32,
  parameter int          KW      = 16,
  parameter logic [63:0] SIG     = 64'h5346_4744_4D41_4321,
  parameter logic [15:0] VER_KEY = 16'h0001,
  parameter logic [7:0]  VER_VAL = 8'h03
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_off,
  input  logic [3:0]    reg_size,
  input  logic [63:0]   reg_wdata,
  output logic [63:0]   reg_rdata,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic [KW-1:0] st_key,
  output logic [LW-1:0] st_off,
  input  logic          st_valid,
  input  logic [LW-1:0] st_len,
  input  logic          st_wok,
  input  logic [7:0]    st_rdata,
  output logic          st_we,
  output logic [7:0]    st_wdata
);

  logic          start;
  logic [AW-1:0] start_addr;
  logic          sel;
  logic [KW-1:0] sel_key;
  logic          adv;
  logic          avail;
  logic          wok;
  logic [7:0]    item_byte;

  cfg_dma_regwin #(.AW(AW), .SIG(SIG)) u_regwin (
    .clk, .rst_n,
    .wr_i(reg_wr), .off_i(reg_off), .size_i(reg_size), .wdata_i(reg_wdata),
    .busy_i(busy), .rdata_o(reg_rdata),
    .start_o(start), .start_addr_o(start_addr)
  );

  cfg_dma_cursor #(.KW(KW), .OW(LW), .VER_KEY(VER_KEY), .VER_VAL(VER_VAL)) u_cursor (
    .clk, .rst_n,
    .sel_i(sel), .sel_key_i(sel_key), .adv_i(adv),
    .st_key_o(st_key), .st_off_o(st_off),
    .st_valid_i(st_valid), .st_len_i(st_len), .st_wok_i(st_wok),
    .st_rdata_i(st_rdata),
    .avail_o(avail), .wok_o(wok), .byte_o(item_byte)
  );

  cfg_dma_ctrl #(.AW(AW), .LW(LW), .KW(KW)) u_ctrl (
    .clk, .rst_n,
    .start_i(start), .start_addr_i(start_addr), .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ack_i(mem_ack), .mem_err_i(mem_err),
    .sel_o(sel), .sel_key_o(sel_key), .adv_o(adv),
    .avail_i(avail), .wok_i(wok), .item_byte_i(item_byte),
    .it_we_o(st_we), .it_wdata_o(st_wdata)
  );

endmodule

// File: tb/cfg_dma_engine_tb_top.sv
module cfg_dma_engine_tb_top;

  localparam logic [63:0] SIGV = 64'h5346_4744_4D41_4321;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_off = '0;
  logic [3:0]  reg_size = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        busy;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic [15:0] st_key;
  logic [31:0] st_off;
  logic        st_valid, st_wok;
  logic [31:0] st_len;
  logic [7:0]  st_rdata;
  logic        st_we;
  logic [7:0]  st_wdata;

  int errors = 0;
  int checks = 0;
  logic [7:0]  mem [4096];
  logic [7:0]  ia [6];
  logic [7:0]  ib [4];
  logic [63:0] err_addr = 64'hFFFF_FFFF_FFFF_FFFF;

  always #5 clk = ~clk;

  cfg_dma_engine dut_i (
    .clk, .rst_n, .reg_wr, .reg_off, .reg_size, .reg_wdata, .reg_rdata, .busy,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack, .mem_err,
    .st_key, .st_off, .st_valid, .st_len, .st_wok, .st_rdata, .st_we, .st_wdata
  );

  // item store: key 0x0020 read-only 6 bytes, key 0x0021 writable 4 bytes
  always @* begin
    st_valid = 1'b0; st_len = 0; st_wok = 1'b0; st_rdata = 8'h00;
    if (st_key == 16'h0020) begin
      st_valid = 1'b1; st_len = 6;
      if (st_off < 6) st_rdata = ia[st_off[2:0]];
    end else if (st_key == 16'h0021) begin
      st_valid = 1'b1; st_len = 4; st_wok = 1'b1;
      if (st_off < 4) st_rdata = ib[st_off[1:0]];
    end
  end

  always @(posedge clk) if (st_we && st_key == 16'h0021 && st_off < 4) ib[st_off[1:0]] <= st_wdata;

  // memory: low 2 KB window at 0x0, high-half window 0x1_0000_0000 aliases 0x800
  function automatic logic map_ok(input logic [63:0] a, output logic [11:0] ix);
    ix = 12'h000;
    if (a == err_addr) return 1'b0;
    if (a[63:11] == '0) begin ix = {1'b0, a[10:0]}; return 1'b1; end
    if (a[63:32] == 32'h1 && a[31:11] == '0) begin ix = {1'b1, a[10:0]}; return 1'b1; end
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    logic [11:0] ix;
    logic        ok;
    if (mem_req && !mem_ack) begin
      ok = map_ok(mem_addr, ix);
      mem_ack <= 1'b1;
      mem_err <= !ok;
      if (ok && mem_we) mem[ix] <= mem_wdata;
      mem_rdata <= ok ? mem[ix] : 8'h00;
    end else begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put32(input int a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[a + i] = v[31 - 8*i -: 8];
  endtask

  task automatic put_desc(input int a, input logic [31:0] ctl, input logic [31:0] len,
                          input logic [63:0] tgt);
    put32(a, ctl); put32(a + 4, len); put32(a + 8, tgt[63:32]); put32(a + 12, tgt[31:0]);
  endtask

  function automatic logic [31:0] get32(input int a);
    return {mem[a], mem[a+1], mem[a+2], mem[a+3]};
  endfunction

  task automatic fill(input int a, input int n, input logic [7:0] v);
    for (int i = 0; i < n; i++) mem[a + i] = v;
  endtask

  task automatic rwrite(input logic [2:0] off, input logic [3:0] sz, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_off = off; reg_size = sz; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input logic [31:0] desc);
    rwrite(3'd0, 4'd4, 64'h0);
    rwrite(3'd4, 4'd4, {32'h0, desc});
    wait_idle();
  endtask

  task automatic rread(input logic [2:0] off, input logic [3:0] sz, input logic [63:0] exp,
                       input string tag);
    @(negedge clk);
    reg_off = off; reg_size = sz;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic t_reset();
    chk("R12 busy after reset", {63'd0, busy}, 64'd0);
    chk("R12 mem_req after reset", {63'd0, mem_req}, 64'd0);
  endtask

  task automatic t_signature();
    rread(3'd0, 4'd8, SIGV, "R1 sig 8@0");
    rread(3'd4, 4'd4, 64'h4D41_4321, "R1 sig 4@4");
    rread(3'd6, 4'd2, 64'h4321, "R1 sig 2@6");
    rread(3'd0, 4'd1, 64'h53, "R1 sig 1@0");
    rread(3'd2, 4'd4, 64'h4744_4D41, "R1 sig 4@2");
    rread(3'd6, 4'd4, 64'h0, "R1 sig span past end");
  endtask

  task automatic t_read_basic();
    put_desc(12'h100, 32'h0020_000A, 6, 64'h180);
    run(32'h100);
    for (int i = 0; i < 6; i++) chk("R6 R3 read byte", mem[12'h180 + i], 8'h10 + 8'(i));
    chk("R9 success status", get32(12'h100), 32'h0);
  endtask

  task automatic t_read_zero();
    fill(12'h1A0, 12, 8'hEE);
    put_desc(12'h110, 32'h0020_000A, 10, 64'h1A0);
    run(32'h110);
    chk("R6 item byte 5", mem[12'h1A5], 8'h15);
    for (int i = 6; i < 10; i++) chk("R6 zero fill", mem[12'h1A0 + i], 8'h00);
    chk("R6 past length untouched", mem[12'h1AA], 8'hEE);
  endtask

  task automatic t_continue();
    put_desc(12'h120, 32'h0020_000A, 2, 64'h1C0);
    put_desc(12'h130, 32'h0000_0002, 2, 64'h1C8);
    run(32'h120);
    run(32'h130);
    chk("R4 no-select continues offset", {mem[12'h1C8], mem[12'h1C9]}, 16'h1213);
  endtask

  task automatic t_skip();
    fill(12'h1D0, 4, 8'hEE);
    put_desc(12'h140, 32'h0020_000C, 3, 64'h1D0);
    put_desc(12'h150, 32'h0000_0002, 3, 64'h1D8);
    run(32'h140);
    chk("R7 skip no memory write", get32(12'h1D0), 32'hEEEE_EEEE);
    chk("R7 skip status", get32(12'h140), 32'h0);
    run(32'h150);
    chk("R7 skip advanced offset", {mem[12'h1D8], mem[12'h1D9], mem[12'h1DA]}, 24'h131415);
  endtask

  task automatic t_priority_read();
    ib[0] = 8'hB0; ib[1] = 8'hB1; ib[2] = 8'hB2; ib[3] = 8'hB3;
    put_desc(12'h160, 32'h0021_001E, 4, 64'h1E0);
    run(32'h160);
    chk("R5 read wins over write/skip", get32(12'h1E0), 32'hB0B1_B2B3);
    chk("R5 item unchanged", {ib[0], ib[1], ib[2], ib[3]}, 32'hB0B1_B2B3);
  endtask

  task automatic t_write();
    put32(12'h280, 32'h5A5B_5C5D);
    put_desc(12'h200, 32'h0021_001C, 4, 64'h280);
    run(32'h200);
    chk("R8 R5 write wins over skip", {ib[0], ib[1], ib[2], ib[3]}, 32'h5A5B_5C5D);
    chk("R8 write status", get32(12'h200), 32'h0);
    put_desc(12'h210, 32'h0021_000A, 4, 64'h290);
    run(32'h210);
    chk("R8 readback", get32(12'h290), 32'h5A5B_5C5D);
  endtask

  task automatic t_write_ro();
    put32(12'h284, 32'h7777_7777);
    put_desc(12'h220, 32'h0020_0018, 2, 64'h284);
    run(32'h220);
    chk("R8 read-only error status", get32(12'h220), 32'h1);
    put_desc(12'h230, 32'h0020_000A, 2, 64'h2A0);
    run(32'h230);
    chk("R8 read-only item intact", {mem[12'h2A0], mem[12'h2A1]}, 16'h1011);
  endtask

  task automatic t_write_over();
    for (int i = 0; i < 6; i++) mem[12'h2B0 + i] = 8'h61 + 8'(i);
    put_desc(12'h240, 32'h0021_0018, 6, 64'h2B0);
    run(32'h240);
    chk("R8 overrun error status", get32(12'h240), 32'h1);
    chk("R8 bytes before overrun", {ib[0], ib[1], ib[2], ib[3]}, 32'h6162_6364);
  endtask

  task automatic t_invalid();
    fill(12'h2D0, 4, 8'hEE);
    put_desc(12'h260, 32'h0055_000A, 3, 64'h2D0);
    run(32'h260);
    chk("R6 invalid key zeros", get32(12'h2D0), 32'h0000_00EE);
    chk("R6 invalid key status", get32(12'h260), 32'h0);
  endtask

  task automatic t_noop();
    fill(12'h2E0, 5, 8'hEE);
    put_desc(12'h270, 32'h0020_0008, 5, 64'h2E0);
    run(32'h270);
    chk("R5 no-op moves nothing", get32(12'h2E0), 32'hEEEE_EEEE);
    chk("R5 no-op status", get32(12'h270), 32'h0);
  endtask

  task automatic t_version();
    fill(12'h380, 4, 8'hEE);
    put_desc(12'h300, 32'h0001_000A, 4, 64'h380);
    run(32'h300);
    chk("R11 version item", get32(12'h380), 32'h0300_0000);
  endtask

  task automatic t_fetch_err();
    fill(12'h680, 2, 8'hEE);
    put_desc(12'h600, 32'h0020_000A, 2, 64'h680);
    err_addr = 64'h605;
    run(32'h600);
    err_addr = 64'hFFFF_FFFF_FFFF_FFFF;
    chk("R10 fetch error status", get32(12'h600), 32'h1);
    chk("R10 fetch error no move", {mem[12'h680], mem[12'h681]}, 16'hEEEE);
  endtask

  task automatic t_xfer_err();
    fill(12'h780, 6, 8'hEE);
    put_desc(12'h700, 32'h0020_000A, 6, 64'h780);
    err_addr = 64'h782;
    run(32'h700);
    err_addr = 64'hFFFF_FFFF_FFFF_FFFF;
    chk("R10 move error status", get32(12'h700), 32'h1);
    chk("R10 bytes before fault", {mem[12'h780], mem[12'h781]}, 16'h1011);
    chk("R10 bytes after fault untouched", get32(12'h782), 32'hEEEE_EEEE);
  endtask

  task automatic t_addr_clear();
    fill(12'hB40, 4, 8'hAA);
    put_desc(12'hB00, 32'h0020_000A, 1, 64'h3C0);
    put_desc(12'h340, 32'h0020_000A, 1, 64'h3C4);
    rwrite(3'd0, 4'd4, 64'h1);
    rwrite(3'd4, 4'd4, 64'h300);
    wait_idle();
    chk("R2 high half used", get32(12'hB00), 32'h0);
    chk("R2 high target", mem[12'h3C0], 8'h10);
    rwrite(3'd4, 4'd4, 64'h340);
    wait_idle();
    chk("R2 high half cleared after start", get32(12'h340), 32'h0);
    chk("R2 stale window untouched", get32(12'hB40), 32'hAAAA_AAAA);
  endtask

  task automatic t_wide_start();
    put_desc(12'h400, 32'h0020_000A, 1, 64'h480);
    rwrite(3'd0, 4'd8, 64'h400);
    wait_idle();
    chk("R2 8-byte start", mem[12'h480], 8'h10);
    chk("R2 8-byte start status", get32(12'h400), 32'h0);
  endtask

  task automatic t_busy_ignore();
    fill(12'h540, 4, 8'hAA);
    put_desc(12'h500, 32'h0020_000A, 6, 64'h580);
    rwrite(3'd0, 4'd8, 64'h500);
    chk("R12 busy after start", {63'd0, busy}, 64'd1);
    rwrite(3'd0, 4'd8, 64'h540);
    wait_idle();
    chk("R2 start ignored while busy", get32(12'h540), 32'hAAAA_AAAA);
    chk("R12 first transfer done", get32(12'h500), 32'h0);
    repeat (3) @(negedge clk);
    chk("R12 stays idle", {63'd0, busy}, 64'd0);
  endtask

  task automatic t_bad_size();
    rwrite(3'd4, 4'd2, 64'h100);
    chk("R2 2-byte write no start", {63'd0, busy}, 64'd0);
    rwrite(3'd2, 4'd4, 64'h100);
    chk("R2 misaligned write no start", {63'd0, busy}, 64'd0);
  endtask

  bit finished = 1'b0;

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    for (int i = 0; i < 6; i++) ia[i] = 8'h10 + 8'(i);
    for (int i = 0; i < 4; i++) ib[i] = 8'hB0 + 8'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_signature();
    t_read_basic();
    t_read_zero();
    t_continue();
    t_skip();
    t_priority_read();
    t_write();
    t_write_ro();
    t_write_over();
    t_invalid();
    t_noop();
    t_version();
    t_fetch_err();
    t_xfer_err();
    t_addr_clear();
    t_wide_start();
    t_busy_ignore();
    t_bad_size();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule